// File: doc/BRIEF.md
# Ring-Chained FIFO Segment

This block builds one deep first-in, first-out queue out of several identical storage segments joined in a ring. Every segment sees the same write, read and reset controls. Each one holds `DEPTH` words of `DATA_W` bits in a local memory. It also keeps two tokens: one for writing and one for reading. A segment stores a word only while it owns the write token, and it delivers a word only while it owns the read token.

When the owner of a token uses its last physical location, it raises a wrap strobe toward the next segment in the ring. There is a write-wrap strobe and a separate read-wrap strobe, so the two tokens travel independently. On that same clock edge the neighbour takes the token and carries on from its location zero. One segment is strapped as the lead with an active-low strap. After reset it alone owns both tokens, and all pointers start at location zero.

The top module wraps `SEGS` segments into the ring. It forms the chain-level full indication by OR-ing the per-segment full flags, and the chain-level empty indication by OR-ing the per-segment empty flags. The read data comes from whichever segment strobed valid. In a ring with a single segment the wrap strobes are never raised, and that segment keeps both tokens.

Top module: `fifo_chain`

## Requirements
- R1: While reset is high, and in the first cycle after it, `empty` is 1, `full` is 0 and `rd_valid` is 0. Only the lead segment (index 0) owns the write and read tokens after reset.
- R2: A read accepted at a clock edge raises `rd_valid` in the following cycle. At that time `rd_data` holds the oldest stored word, so words leave in strict write order.
- R3: `full` is 1 exactly when `SEGS*DEPTH` words are stored. A write request while `full` is 1 stores nothing and does not disturb the order of the stored words.
- R4: `empty` is 1 exactly when no word is stored. A read request while `empty` is 1 is ignored, and `rd_valid` is 0 in the following cycle.
- R5: A segment that accepts a write into location `DEPTH-1` gives up the write token. On the same edge, segment (index+1) mod `SEGS` takes it, and its next write goes to location 0. Exactly one segment owns the write token at any time.
- R6: The read token moves around the ring in the same way, after a read from location `DEPTH-1`, independently of the write token. Exactly one segment owns it at any time.
- R7: A segment without the write token leaves its write pointer unchanged whatever `wr_en` does. A segment without the read token keeps its valid strobe low, so at most one segment presents data in any cycle.
- R8: When neither flag blocks, a write and a read in the same cycle are both accepted. When `full` is 1, the write is ignored even if a read happens in the same cycle. When `empty` is 1, the read is ignored even if a write happens in the same cycle, and the written word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all segments |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Word delivered by the read token owner |
| rd_valid | output | 1 | `rd_data` holds a word read at the previous edge |
| full | output | 1 | Chain holds `SEGS*DEPTH` words |
| empty | output | 1 | Chain holds no word |

## Verification
The bench builds the chain with `DEPTH=8` and `SEGS=3`, a capacity of 24 words. With so small a capacity, both tokens cross segment boundaries every eight operations and complete a full lap of the ring within a few dozen cycles. Several thousand random cycles therefore move both tokens through hundreds of wraps. Alternating write-heavy and read-heavy phases drive the chain repeatedly into the full and empty states. In those states the blocked requests and the same-cycle write/read corner cases meet tokens sitting at every segment and pointer position.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;
  // Pair of one-cycle wrap strobes sent from a segment to its ring neighbour.
  typedef struct packed {
    logic wr;   // write token handed over
    logic rd;   // read token handed over
  } wrap_t;
endpackage

// File: rtl/seg_store.sv
// Simple dual-port storage with a registered read port (block-RAM friendly).
module seg_store #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/seg_ctrl.sv
// Token, pointer and occupancy control of one ring segment.
module seg_ctrl
  import fifo_chain_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int AW      = 4,
  parameter bit CHAINED = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lead_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  wrap_t         xi,
  output wrap_t         xo,
  output logic          wr_go,
  output logic          rd_go,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic          full_o,
  output logic          empty_o,
  output logic          valid_o,
  output logic          wtok_o,
  output logic          rtok_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          wtok, rtok;
  logic [CW-1:0] cnt;
  logic          loc_full, loc_empty, wr_last, rd_last;

  assign loc_full  = (cnt == CW'(DEPTH));
  assign loc_empty = (cnt == '0);
  assign wr_last   = (wptr == LAST);
  assign rd_last   = (rptr == LAST);

  assign wr_go = wr_en & wtok & ~loc_full;
  assign rd_go = rd_en & rtok & ~loc_empty;

  // Strobes coincide with the wrapping access so no cycle is left tokenless.
  assign xo.wr = CHAINED & wr_go & wr_last;
  assign xo.rd = CHAINED & rd_go & rd_last;

  // Flags are reported only by the token owner; the chain ORs them.
  assign full_o  = wtok & loc_full;
  assign empty_o = rtok & loc_empty;
  assign wtok_o  = wtok;
  assign rtok_o  = rtok;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      cnt     <= '0;
      wtok    <= ~lead_n;
      rtok    <= ~lead_n;
      valid_o <= 1'b0;
    end else begin
      if (wr_go) wptr <= wr_last ? '0 : wptr + 1'b1;
      if (rd_go) rptr <= rd_last ? '0 : rptr + 1'b1;

      if (wr_go && !rd_go)      cnt <= cnt + 1'b1;
      else if (!wr_go && rd_go) cnt <= cnt - 1'b1;

      if (CHAINED) begin
        if (xi.wr)      wtok <= 1'b1;
        else if (xo.wr) wtok <= 1'b0;
        if (xi.rd)      rtok <= 1'b1;
        else if (xo.rd) rtok <= 1'b0;
      end

      valid_o <= rd_go;
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  assert_wr_handoff_R5: assert property (@(posedge clk) disable iff (rst)
    xi.wr |-> (wptr == '0 && !wtok));

  assert_wr_release_R5: assert property (@(posedge clk) disable iff (rst)
    xo.wr |=> !wtok);

  assert_rd_handoff_R6: assert property (@(posedge clk) disable iff (rst)
    xi.rd |-> (rptr == '0 && !rtok));

  assert_rd_release_R6: assert property (@(posedge clk) disable iff (rst)
    xo.rd |=> !rtok);

  assert_idle_wptr_R7: assert property (@(posedge clk) disable iff (rst)
    !wtok |=> $stable(wptr));

  assert_valid_owner_R7: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(rtok));
endmodule

// File: rtl/chain_seg.sv
// One ring segment: control plus local storage.
module chain_seg
  import fifo_chain_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int DEPTH   = 16,
  parameter bit CHAINED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lead_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  wrap_t             xi,
  output wrap_t             xo,
  output logic [DATA_W-1:0] dout,
  output logic              valid_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              wtok_o,
  output logic              rtok_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          wr_go, rd_go;
  logic [AW-1:0] wptr, rptr;

  seg_ctrl #(.DEPTH(DEPTH), .AW(AW), .CHAINED(CHAINED)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .lead_n  (lead_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .xi      (xi),
    .xo      (xo),
    .wr_go   (wr_go),
    .rd_go   (rd_go),
    .wptr    (wptr),
    .rptr    (rptr),
    .full_o  (full_o),
    .empty_o (empty_o),
    .valid_o (valid_o),
    .wtok_o  (wtok_o),
    .rtok_o  (rtok_o)
  );

  seg_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk   (clk),
    .we    (wr_go),
    .waddr (wptr),
    .wdata (wr_data),
    .re    (rd_go),
    .raddr (rptr),
    .rdata (dout)
  );
endmodule

// File: rtl/fifo_chain.sv
// Ring of SEGS segments forming one queue of SEGS*DEPTH words.
module fifo_chain
  import fifo_chain_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16,
  parameter int SEGS   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              full,
  output logic              empty
);
  localparam bit CHAINED = (SEGS > 1);

  wrap_t             xo_v   [SEGS];
  logic [DATA_W-1:0] dout_v [SEGS];
  logic [SEGS-1:0]   valid_v, full_v, empty_v, wtok_v, rtok_v;

  for (genvar g = 0; g < SEGS; g++) begin : g_seg
    chain_seg #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CHAINED(CHAINED)) u_seg (
      .clk     (clk),
      .rst     (rst),
      .lead_n  ((g == 0) ? 1'b0 : 1'b1),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .xi      (xo_v[(g + SEGS - 1) % SEGS]),
      .xo      (xo_v[g]),
      .dout    (dout_v[g]),
      .valid_o (valid_v[g]),
      .full_o  (full_v[g]),
      .empty_o (empty_v[g]),
      .wtok_o  (wtok_v[g]),
      .rtok_o  (rtok_v[g])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < SEGS; k++)
      if (valid_v[k]) rd_data = rd_data | dout_v[k];
  end

  assign rd_valid = |valid_v;
  assign full     = |full_v;
  assign empty    = |empty_v;

  assert_one_wtok_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(wtok_v) == 1);

  assert_one_rtok_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(rtok_v) == 1);

  assert_single_source_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(valid_v));

  assert_flag_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
endmodule

// File: tb/fifo_chain_bench.sv
module fifo_chain_bench;
  localparam int W   = 9;
  localparam int D   = 8;
  localparam int S   = 3;
  localparam int CAP = D * S;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         rd_valid, full, empty;

  int n_chk = 0;
  int n_bad = 0;
  int q[$];

  always #4 clk = ~clk;

  fifo_chain #(.DATA_W(W), .DEPTH(D), .SEGS(S)) u_fifo_chain (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .full(full), .empty(empty)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_full();
    return q.size() == CAP;
  endfunction

  function automatic bit exp_empty();
    return q.size() == 0;
  endfunction

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input bit we, input bit re, input logic [W-1:0] d);
    bit aw, ar;
    int e;
    chk("R3 full flag", int'(full), int'(exp_full()));
    chk("R4 empty flag", int'(empty), int'(exp_empty()));
    aw = we && !exp_full();
    ar = re && !exp_empty();
    wr_en = we; rd_en = re; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R7 R8 read strobe", int'(rd_valid), int'(ar));
    if (ar) begin
      e = q.pop_front();
      chk("R2 R5 R6 order", int'(rd_data), e);
    end
    if (aw) q.push_back(int'(d));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 empty in reset", int'(empty), 1);
    chk("R1 full in reset", int'(full), 0);
    chk("R1 valid in reset", int'(rd_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 empty after reset", int'(empty), 1);
    chk("R1 valid after reset", int'(rd_valid), 0);

    // Fill the whole ring: write token crosses every boundary (R5).
    for (int i = 0; i < CAP; i++) step(1'b1, 1'b0, W'(i + 1));
    chk("R3 full at capacity", int'(full), 1);
    // Writes while full are dropped (R3).
    step(1'b1, 1'b0, W'('h1AA));
    step(1'b1, 1'b0, W'('h0AA));
    // Write and read together while full: only the read counts (R8).
    step(1'b1, 1'b1, W'('h155));
    // Drain: read token crosses every boundary (R6).
    while (q.size() > 0) step(1'b0, 1'b1, '0);
    chk("R4 empty after drain", int'(empty), 1);
    // Reads while empty are dropped (R4).
    step(1'b0, 1'b1, '0);
    step(1'b0, 1'b1, '0);
    // Write and read together while empty: only the write counts (R8).
    step(1'b1, 1'b1, W'('h0F0));
    chk("R8 word kept", q.size(), 1);
    step(1'b0, 1'b1, '0);

    // Random traffic, alternating write-heavy and read-heavy phases.
    for (int i = 0; i < 6000; i++) begin
      bit heavy_w;
      int pw, pr;
      heavy_w = ((i / 150) % 2) == 0;
      pw = heavy_w ? 75 : 35;
      pr = heavy_w ? 35 : 75;
      step(($urandom % 100) < pw, ($urandom % 100) < pr, W'($urandom % 512));
    end

    while (q.size() > 0) step(1'b0, 1'b1, '0);
    step(1'b0, 1'b0, '0);
    summary();
    $finish;
  end
endmodule